// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block is the micro-sequencer that moves a processor's working context to and from a byte-wide stack memory when an interrupt is taken and when the handler returns. On an accepted entry strobe it captures the register values, writes them as a nine-byte frame, one byte per clock, while the stack pointer walks downward. Once the condition-code byte is stored, it raises the interrupt mask bits. It then reads a two-byte vector from the address the arbiter supplied and loads it into the program counter.

On a return strobe it reads the nine frame bytes back in the opposite order. The stack pointer is pre-incremented before each read, so it ends at its original value and the mask bits come back exactly as they were saved. Memory reads are combinational: `mem_rdata` must be valid in the same cycle as `mem_rd` and `mem_addr`. Decoding the instruction and choosing the winning source happen elsewhere.

Top module: `irq_frame_seq`

## Requirements
- R1: On entry, the nine cycles after the accepted strobe each write one byte at `sp_in - k` for k = 0..8, in this order: PC[7:0], PC[15:8], IY[7:0], IY[15:8], IX[7:0], IX[15:8], A, B, CCR.
- R2: The stored CCR byte is the pre-entry value. `ccr_out` does not change during the nine write cycles. Bit 4 (I mask) of `ccr_out` is set from the cycle after the CCR write.
- R3: Bit 6 (X mask) of `ccr_out` is set after the CCR write only when `entry_nmi` was high with the strobe. Otherwise it keeps its captured value.
- R4: After stacking, the block reads the vector high byte at `vec_addr` and then the low byte at `vec_addr + 1`. `pc_out` then equals {high, low}.
- R5: At the end of entry, `sp_out` equals `sp_in - 9`.
- R6: On return, nine reads at `sp_in + 1 .. sp_in + 9` restore CCR, B, A, IX[15:8], IX[7:0], IY[15:8], IY[7:0], PC[15:8], PC[7:0] in that order. `sp_out` then equals `sp_in + 9`, and both mask bits take their saved values.
- R7: `busy` is high for exactly 11 cycles on entry and exactly 9 cycles on return, starting the cycle after the strobe. `done` pulses for one cycle in the first cycle after that.
- R8: Entry or return strobes that arrive while `busy` is high have no effect on the running sequence.
- R9: If both strobes arrive together while idle, entry is performed.
- R10: After reset, `busy`, `done`, `mem_wr` and `mem_rd` are low, and all context outputs are zero.
- R11: No memory access is made while the block is idle, and a cycle never both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_go | input | 1 | Start interrupt entry (one-cycle strobe) |
| entry_nmi | input | 1 | Entry is for the non-maskable source |
| vec_addr | input | 16 | Vector address of the winning source |
| rti_go | input | 1 | Start return from interrupt (one-cycle strobe) |
| pc_in | input | 16 | Program counter to capture |
| iy_in | input | 16 | Y index to capture |
| ix_in | input | 16 | X index to capture |
| acc_a_in | input | 8 | Accumulator A to capture |
| acc_b_in | input | 8 | Accumulator B to capture |
| ccr_in | input | 8 | Condition codes to capture |
| sp_in | input | 16 | Stack pointer to capture |
| mem_addr | output | 16 | Stack/vector memory address |
| mem_wr | output | 1 | Byte write strobe |
| mem_rd | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| iy_out | output | 16 | Resulting Y index |
| ix_out | output | 16 | Resulting X index |
| acc_a_out | output | 8 | Resulting accumulator A |
| acc_b_out | output | 8 | Resulting accumulator B |
| ccr_out | output | 8 | Resulting condition codes |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
The hardest situation to reach from the ports is a strobe landing in the middle of a running sequence. This includes the case where both strobes fire mid-entry, which might restart the frame or switch it to a return. The bench injects both strobes on the fourth cycle of an entry and of a return. It then requires every later byte, address and the completion cycle to match the undisturbed reference. The mask ordering is checked directly: the bench confirms the stored CCR byte still carries clear mask bits, while `ccr_out` shows them set one cycle later. A final case starts with the X bit already set on a maskable entry and checks that it is kept.

// File: rtl/irq_frame_pkg.sv
// Package: shared constants, types and frame helpers for the interrupt
// context stacking sequencer. Assumes 8-bit data and 16-bit addresses.
package irq_frame_pkg;

    localparam int DW          = 8;
    localparam int AW          = 16;
    localparam int FRAME_BYTES = 9;
    localparam int VEC_BYTES   = 2;
    localparam int CNT_W       = $clog2(FRAME_BYTES);
    localparam int I_POS       = 4;
    localparam int X_POS       = 6;
    localparam int ENTRY_LEN   = FRAME_BYTES + VEC_BYTES;
    localparam int RTI_LEN     = FRAME_BYTES;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_PUSH = 3'd1,
        SQ_VHI  = 3'd2,
        SQ_VLO  = 3'd3,
        SQ_PULL = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [2*DW-1:0] pc;
        logic [2*DW-1:0] iy;
        logic [2*DW-1:0] ix;
        logic [DW-1:0]   a;
        logic [DW-1:0]   b;
        logic [DW-1:0]   ccr;
    } ctx_t;

    // Byte of the frame held in slot idx (slot idx sits at SP - idx).
    function automatic logic [DW-1:0] frame_pick(input ctx_t c, input logic [CNT_W-1:0] idx);
        logic [DW-1:0] r;
        case (idx)
            4'd0:    r = c.pc[DW-1:0];
            4'd1:    r = c.pc[2*DW-1:DW];
            4'd2:    r = c.iy[DW-1:0];
            4'd3:    r = c.iy[2*DW-1:DW];
            4'd4:    r = c.ix[DW-1:0];
            4'd5:    r = c.ix[2*DW-1:DW];
            4'd6:    r = c.a;
            4'd7:    r = c.b;
            default: r = c.ccr;
        endcase
        return r;
    endfunction

    // Context with slot idx replaced by byte v.
    function automatic ctx_t frame_put(input ctx_t c, input logic [CNT_W-1:0] idx, input logic [DW-1:0] v);
        ctx_t r;
        r = c;
        case (idx)
            4'd0:    r.pc[DW-1:0]     = v;
            4'd1:    r.pc[2*DW-1:DW]  = v;
            4'd2:    r.iy[DW-1:0]     = v;
            4'd3:    r.iy[2*DW-1:DW]  = v;
            4'd4:    r.ix[DW-1:0]     = v;
            4'd5:    r.ix[2*DW-1:DW]  = v;
            4'd6:    r.a              = v;
            4'd7:    r.b              = v;
            default: r.ccr            = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_seq_ctrl.sv
// Module: sequence controller. Accepts entry/return strobes only while idle
// (entry wins a tie), steps a slot counter through the frame and the vector
// fetch, and emits busy and a one-cycle done pulse.
// Assumes strobes are single-cycle requests from a synchronous source.
module irq_seq_ctrl
    import irq_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_go,
    input  logic             rti_go,
    output seq_state_e       state,
    output logic [CNT_W-1:0] slot,
    output logic             take_entry,
    output logic             take_rti,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_BYTES - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q;

    // Accept a request only from idle; entry has priority.
    always_comb begin
        take_entry = (st_q == SQ_IDLE) && entry_go;
        take_rti   = (st_q == SQ_IDLE) && !entry_go && rti_go;
    end

    // Next-state and slot counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            SQ_IDLE: begin
                cnt_d = '0;
                if (take_entry)    st_d = SQ_PUSH;
                else if (take_rti) st_d = SQ_PULL;
            end
            SQ_PUSH: begin
                if (cnt_q == LAST_SLOT) begin
                    st_d  = SQ_VHI;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            SQ_VHI:  st_d = SQ_VLO;
            SQ_VLO:  st_d = SQ_IDLE;
            SQ_PULL: begin
                if (cnt_q == LAST_SLOT) begin
                    st_d  = SQ_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // State, counter and completion pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            done_q <= (st_q == SQ_VLO) || (st_q == SQ_PULL && cnt_q == LAST_SLOT);
        end
    end

    assign state = st_q;
    assign slot  = cnt_q;
    assign busy  = (st_q != SQ_IDLE);
    assign done  = done_q;

    // Checker support: length of the running operation and its kind.
    logic [4:0] op_len_q;
    logic       op_entry_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_len_q   <= '0;
            op_entry_q <= 1'b0;
        end else if (take_entry || take_rti) begin
            op_len_q   <= '0;
            op_entry_q <= take_entry;
        end else if (busy) begin
            op_len_q   <= op_len_q + 5'd1;
        end
    end

    // R7: done follows exactly the expected number of busy cycles.
    p_op_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (op_len_q == (op_entry_q ? 5'(ENTRY_LEN) : 5'(RTI_LEN))));

    // R7: done only ever follows a busy cycle and never overlaps busy.
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R8: a strobe while busy does not return the sequence to its start.
    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q != SQ_VLO && !(st_q == SQ_PULL && cnt_q == LAST_SLOT)) |=> busy);

endmodule

// File: rtl/irq_mem_port.sv
// Module: memory port driver. Decodes the controller state into the address,
// direction and write byte of the single byte-wide memory port.
// Assumes combinational read data and that the controller holds one state per cycle.
module irq_mem_port
    import irq_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state,
    input  logic [CNT_W-1:0] slot,
    input  logic [AW-1:0]    sp_q,
    input  logic [AW-1:0]    vec_q,
    input  ctx_t             ctx_q,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_wr,
    output logic             mem_rd,
    output logic [DW-1:0]    mem_wdata
);

    // Per-state drive of the memory port.
    always_comb begin
        mem_addr  = '0;
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = '0;
        case (state)
            SQ_PUSH: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_q;
                mem_wdata = frame_pick(ctx_q, slot);
            end
            SQ_VHI: begin
                mem_rd    = 1'b1;
                mem_addr  = vec_q;
            end
            SQ_VLO: begin
                mem_rd    = 1'b1;
                mem_addr  = vec_q + AW'(1);
            end
            SQ_PULL: begin
                mem_rd    = 1'b1;
                mem_addr  = sp_q + AW'(1);
            end
            default: ;
        endcase
    end

    // R11: never read and write in the same cycle.
    p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R11: idle means no access at all.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE) |-> (!mem_wr && !mem_rd));

endmodule

// File: rtl/irq_ctx_regs.sv
// Module: context and pointer registers. Captures the inputs on an accepted
// strobe, walks the stack pointer, raises the mask bits after the CCR byte is
// written, loads the vector into PC, and restores slots during return.
// Assumes the controller supplies one-hot take strobes from idle.
module irq_ctx_regs
    import irq_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state,
    input  logic [CNT_W-1:0] slot,
    input  logic             take_entry,
    input  logic             take_rti,
    input  logic             entry_nmi,
    input  logic [AW-1:0]    vec_addr,
    input  ctx_t             ctx_in,
    input  logic [AW-1:0]    sp_in,
    input  logic [DW-1:0]    mem_rdata,
    output ctx_t             ctx_q,
    output logic [AW-1:0]    sp_q,
    output logic [AW-1:0]    vec_q
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_BYTES - 1);

    logic nmi_q;
    logic [CNT_W-1:0] pull_slot;

    // Return reads the frame from the CCR end toward the PC end.
    assign pull_slot = LAST_SLOT - slot;

    // Request capture: vector address and entry kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            nmi_q <= 1'b0;
        end else if (take_entry) begin
            vec_q <= vec_addr;
            nmi_q <= entry_nmi;
        end
    end

    // Stack pointer: capture, post-decrement on push, pre-increment on pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (take_entry || take_rti) begin
            sp_q <= sp_in;
        end else if (state == SQ_PUSH) begin
            sp_q <= sp_q - AW'(1);
        end else if (state == SQ_PULL) begin
            sp_q <= sp_q + AW'(1);
        end
    end

    // Context: capture, mask update after CCR write, vector load, restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (take_entry || take_rti) begin
            ctx_q <= ctx_in;
        end else begin
            case (state)
                SQ_PUSH: begin
                    if (slot == LAST_SLOT) begin
                        ctx_q.ccr[I_POS] <= 1'b1;
                        if (nmi_q) ctx_q.ccr[X_POS] <= 1'b1;
                    end
                end
                SQ_VHI:  ctx_q.pc[2*DW-1:DW] <= mem_rdata;
                SQ_VLO:  ctx_q.pc[DW-1:0]    <= mem_rdata;
                SQ_PULL: ctx_q <= frame_put(ctx_q, pull_slot, mem_rdata);
                default: ;
            endcase
        end
    end

    // R5: each stacking cycle moves the pointer down by one.
    p_sp_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PUSH) |=> (sp_q == $past(sp_q) - AW'(1)));

    // R6: each pull cycle moves the pointer up by one.
    p_sp_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PULL) |=> (sp_q == $past(sp_q) + AW'(1)));

    // R2: condition codes are untouched before the CCR byte is stored.
    p_ccr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PUSH && slot != LAST_SLOT) |=> $stable(ctx_q.ccr));

    // R2: I mask is set right after the CCR byte is stored.
    p_imask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PUSH && slot == LAST_SLOT) |=> ctx_q.ccr[I_POS]);

    // R3: a maskable entry leaves the X mask as it was.
    p_xmask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PUSH && slot == LAST_SLOT && !nmi_q) |=> $stable(ctx_q.ccr[X_POS]));

endmodule

// File: rtl/irq_frame_seq.sv
// Module: top of the interrupt context stacking sequencer. Connects the
// controller, the context registers and the memory port driver.
// Assumes a byte memory with same-cycle read data and one request at a time.
module irq_frame_seq
    import irq_frame_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          entry_go,
    input  logic          entry_nmi,
    input  logic [15:0]   vec_addr,
    input  logic          rti_go,
    input  logic [15:0]   pc_in,
    input  logic [15:0]   iy_in,
    input  logic [15:0]   ix_in,
    input  logic [7:0]    acc_a_in,
    input  logic [7:0]    acc_b_in,
    input  logic [7:0]    ccr_in,
    input  logic [15:0]   sp_in,
    output logic [15:0]   mem_addr,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [15:0]   pc_out,
    output logic [15:0]   iy_out,
    output logic [15:0]   ix_out,
    output logic [7:0]    acc_a_out,
    output logic [7:0]    acc_b_out,
    output logic [7:0]    ccr_out,
    output logic [15:0]   sp_out
);

    seq_state_e       state;
    logic [CNT_W-1:0] slot;
    logic             take_entry, take_rti;
    ctx_t             ctx_in, ctx_q;
    logic [AW-1:0]    sp_q, vec_q;

    // Pack the incoming register values into one context word.
    always_comb begin
        ctx_in.pc  = pc_in;
        ctx_in.iy  = iy_in;
        ctx_in.ix  = ix_in;
        ctx_in.a   = acc_a_in;
        ctx_in.b   = acc_b_in;
        ctx_in.ccr = ccr_in;
    end

    irq_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_go   (entry_go),
        .rti_go     (rti_go),
        .state      (state),
        .slot       (slot),
        .take_entry (take_entry),
        .take_rti   (take_rti),
        .busy       (busy),
        .done       (done)
    );

    irq_ctx_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .slot       (slot),
        .take_entry (take_entry),
        .take_rti   (take_rti),
        .entry_nmi  (entry_nmi),
        .vec_addr   (vec_addr),
        .ctx_in     (ctx_in),
        .sp_in      (sp_in),
        .mem_rdata  (mem_rdata),
        .ctx_q      (ctx_q),
        .sp_q       (sp_q),
        .vec_q      (vec_q)
    );

    irq_mem_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .slot      (slot),
        .sp_q      (sp_q),
        .vec_q     (vec_q),
        .ctx_q     (ctx_q),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd),
        .mem_wdata (mem_wdata)
    );

    // Present the working context on the output pins.
    assign pc_out    = ctx_q.pc;
    assign iy_out    = ctx_q.iy;
    assign ix_out    = ctx_q.ix;
    assign acc_a_out = ctx_q.a;
    assign acc_b_out = ctx_q.b;
    assign ccr_out   = ctx_q.ccr;
    assign sp_out    = sp_q;

    // R9: a tie between the strobes in idle starts an entry (a write cycle).
    p_entry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && entry_go && rti_go) |=> (mem_wr && !mem_rd));

    // R1: the first entry write goes to the captured stack pointer.
    p_first_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && entry_go) |=> (mem_addr == $past(sp_in)));

endmodule

// File: tb/tb_irq_frame_seq.sv
// Bench: behavioural reference for each operation, compared every cycle.
module tb_irq_frame_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_go = 1'b0, entry_nmi = 1'b0, rti_go = 1'b0;
    logic [15:0] vec_addr = '0, pc_in = '0, iy_in = '0, ix_in = '0, sp_in = '0;
    logic [7:0]  acc_a_in = '0, acc_b_in = '0, ccr_in = '0;
    logic [15:0] mem_addr, pc_out, iy_out, ix_out, sp_out;
    logic        mem_wr, mem_rd, busy, done;
    logic [7:0]  mem_wdata, mem_rdata, acc_a_out, acc_b_out, ccr_out;

    logic [7:0]  bmem [0:1023];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[9:0]];

    // Bench-owned memory stores what the block writes.
    always @(posedge clk) if (mem_wr) bmem[mem_addr[9:0]] <= mem_wdata;

    irq_frame_seq dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference entry sequence; poke injects both strobes mid-run.
    task automatic do_entry(input logic [15:0] pc, iy, ix, input logic [7:0] a, b, ccr,
                            input logic [15:0] sp, vec, input logic nmi, input logic tie, input logic poke);
        logic [7:0] fr [9];
        logic [7:0] exp_ccr;
        fr[0] = pc[7:0]; fr[1] = pc[15:8]; fr[2] = iy[7:0]; fr[3] = iy[15:8];
        fr[4] = ix[7:0]; fr[5] = ix[15:8]; fr[6] = a; fr[7] = b; fr[8] = ccr;
        exp_ccr = ccr | 8'h10 | (nmi ? 8'h40 : 8'h00);
        pc_in = pc; iy_in = iy; ix_in = ix; acc_a_in = a; acc_b_in = b; ccr_in = ccr;
        sp_in = sp; vec_addr = vec; entry_nmi = nmi;
        entry_go = 1'b1; rti_go = tie;
        @(negedge clk);
        entry_go = 1'b0; rti_go = 1'b0;
        for (int k = 0; k < 11; k++) begin
            entry_go = poke && (k == 3);
            rti_go   = poke && (k == 3);
            chk(busy === 1'b1 && done === 1'b0, "R7 busy during entry", {busy, done}, 2'b10);
            if (k < 9) begin
                chk(mem_wr === 1'b1 && mem_rd === 1'b0, tie ? "R9 tie gives write" : (poke ? "R8 write dir" : "R1 write dir"), {mem_wr, mem_rd}, 2'b10);
                chk(mem_addr === sp - 16'(k), "R1 push addr", mem_addr, sp - 16'(k));
                chk(mem_wdata === fr[k], "R1 push byte", mem_wdata, fr[k]);
                chk(ccr_out === ccr, "R2 ccr held while stacking", ccr_out, ccr);
            end else begin
                chk(mem_rd === 1'b1 && mem_wr === 1'b0, "R4 vector read dir", {mem_wr, mem_rd}, 2'b01);
                chk(mem_addr === vec + 16'(k - 9), "R4 vector addr", mem_addr, vec + 16'(k - 9));
                chk(ccr_out[4] === 1'b1, "R2 I mask after ccr write", ccr_out, exp_ccr);
                chk(ccr_out === exp_ccr, "R3 X mask rule", ccr_out, exp_ccr);
            end
            @(negedge clk);
        end
        entry_go = 1'b0; rti_go = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R7 done after entry", {busy, done}, 2'b01);
        chk(pc_out === {bmem[vec[9:0]], bmem[vec[9:0] + 10'd1]}, "R4 pc loaded", pc_out, {bmem[vec[9:0]], bmem[vec[9:0] + 10'd1]});
        chk(sp_out === sp - 16'd9, "R5 sp after entry", sp_out, sp - 16'd9);
        chk(!mem_wr && !mem_rd, "R11 quiet when idle", {mem_wr, mem_rd}, 2'b00);
        @(negedge clk);
        chk(done === 1'b0, "R7 done one cycle", done, 1'b0);
    endtask

    // Reference return sequence; expected context is the pre-entry one.
    task automatic do_rti(input logic [15:0] sp, input logic [15:0] pc, iy, ix,
                          input logic [7:0] a, b, ccr, input logic poke);
        pc_in = 16'hDEAD; iy_in = 16'hBEEF; ix_in = 16'hCAFE;
        acc_a_in = 8'h5A; acc_b_in = 8'hA5; ccr_in = 8'hFF; sp_in = sp;
        rti_go = 1'b1;
        @(negedge clk);
        rti_go = 1'b0;
        for (int k = 0; k < 9; k++) begin
            entry_go = poke && (k == 3);
            rti_go   = poke && (k == 3);
            chk(busy === 1'b1, poke ? "R8 busy kept in return" : "R7 busy in return", busy, 1'b1);
            chk(mem_rd === 1'b1 && mem_wr === 1'b0, "R6 pull dir", {mem_wr, mem_rd}, 2'b01);
            chk(mem_addr === sp + 16'(k + 1), "R6 pull addr", mem_addr, sp + 16'(k + 1));
            @(negedge clk);
        end
        entry_go = 1'b0; rti_go = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R7 done after return", {busy, done}, 2'b01);
        chk(sp_out === sp + 16'd9, "R6 sp restored", sp_out, sp + 16'd9);
        chk(pc_out === pc && iy_out === iy && ix_out === ix, "R6 16-bit regs", {pc_out, iy_out}, {pc, iy});
        chk(ix_out === ix, "R6 ix", ix_out, ix);
        chk(acc_a_out === a && acc_b_out === b, "R6 accumulators", {acc_a_out, acc_b_out}, {a, b});
        chk(ccr_out === ccr, "R6 masks restored", ccr_out, ccr);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
        bmem[10'h300] = 8'hE1; bmem[10'h301] = 8'h2C;
        bmem[10'h3FE] = 8'h9B; bmem[10'h3FF] = 8'h47;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset handshake", {busy, done}, 2'b00);
        chk(mem_wr === 1'b0 && mem_rd === 1'b0, "R10 reset port", {mem_wr, mem_rd}, 2'b00);
        chk(pc_out === 16'h0 && sp_out === 16'h0 && ccr_out === 8'h0, "R10 reset context", {pc_out, sp_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_wr && !mem_rd, "R11 idle after reset", {mem_wr, mem_rd}, 2'b00);

        do_entry(16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h00, 16'h01F0, 16'h0300, 1'b0, 1'b0, 1'b0);
        do_rti(16'h01E7, 16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h00, 1'b0);

        do_entry(16'hA55A, 16'h0F0F, 16'hF00F, 8'h7E, 8'h81, 8'h05, 16'h0250, 16'h03FE, 1'b1, 1'b0, 1'b0);
        do_rti(16'h0247, 16'hA55A, 16'h0F0F, 16'hF00F, 8'h7E, 8'h81, 8'h05, 1'b1);

        do_entry(16'h4321, 16'h1111, 16'h2222, 8'h33, 8'h44, 8'h41, 16'h0120, 16'h0300, 1'b0, 1'b1, 1'b1);
        do_rti(16'h0117, 16'h4321, 16'h1111, 16'h2222, 8'h33, 8'h44, 8'h41, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule